// File: doc/BRIEF.md
# Link Low-Power Entry Gate

This block sits on the transmit side of a serial link. It decides when the link may leave its active state for a light standby state (L0s) or a deeper sleep state (L1). Software can ask for L1. Hardware can ask on its own for L0s or L1. Either way, the gate holds the grant until every transmitted packet has been acknowledged by the link partner. It also keeps retransmission available for as long as an entry is pending.

The retry buffer is tracked as a count of outstanding packets:

- Each transmitted packet adds one to the count.
- Each acknowledgement removes the number of packets it covers.
- A negative acknowledgement leaves the count alone and raises a retransmit request.

The entry state machine has four states: ACTIVE, WAIT_EMPTY, L0S and L1. It moves from WAIT_EMPTY to the requested low-power state only once the registered buffer status shows an empty buffer with no retransmission running.

Top module: `link_lowpower_gate`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) leaves the gate in ACTIVE with a zero outstanding count, grant_l0s and grant_l1 low, and retx_req low.
- R2: Neither grant is asserted while the outstanding count is nonzero or a retransmission is in progress. A retransmission is in progress from a nak_valid until a retx_done.
- R3: The outstanding count rises by one for each tx_sent pulse. It falls by ack_count on each ack_valid pulse, clamped at zero. It is unchanged by nak_valid.
- R4: A nak_valid pulse raises retx_req for exactly the next clock cycle, in any entry state including a pending entry.
- R5: With sw_l1_req held, grant_l1 rises one clock after the buffer has been registered empty. From ACTIVE with an empty buffer, it rises two clocks after the request.
- R6: hw_l1_req held gives the same L1 entry timing as R5.
- R7: An autonomous L0s request (hw_l0s_req) is eligible only when tx_pending is low or fc_credit_ok is low. With tx_pending and fc_credit_ok both high, L0s is never granted.
- R8: When an L1 request (software or hardware) and an eligible L0s request are present together, the gate enters L1. If an L1 request appears while the gate is in L0s, the gate drops back to ACTIVE and then proceeds to L1.
- R9: In WAIT_EMPTY or L0S, a tx_sent pulse or a change or withdrawal of the selected request returns the gate to ACTIVE at the next edge, with grants low.
- R10: L1 is left only when both L1 requests are low; grant_l1 falls at the next edge.
- R11: If no acknowledgement ever arrives for a transmitted packet, no grant is ever given, however long a request is held.
- R12: grant_l0s and grant_l1 are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_l1_req | input | 1 | Software-directed L1 request (level) |
| hw_l1_req | input | 1 | Autonomous L1 request (level) |
| hw_l0s_req | input | 1 | Autonomous L0s request (level) |
| tx_sent | input | 1 | One new packet placed on the link and into the retry buffer |
| ack_valid | input | 1 | Acknowledgement received |
| ack_count | input | CNT_W | Number of packets the acknowledgement covers |
| nak_valid | input | 1 | Negative acknowledgement received |
| retx_done | input | 1 | Retransmission of the retry buffer finished |
| tx_pending | input | 1 | A packet is waiting to be transmitted |
| fc_credit_ok | input | 1 | Flow-control credits allow the waiting packet to be sent |
| grant_l0s | output | 1 | Link may be in L0s |
| grant_l1 | output | 1 | Link may be in L1 |
| retx_req | output | 1 | Retransmit the retry buffer |

## Verification
The entry function is exercised with several distinct request patterns:

- **Requests with packets outstanding.** These are released by partial and then final acknowledgements, which separates a gate that watches the count from one that watches only acknowledgement events.
- **A negative acknowledgement during a pending L1 entry.** This shows that an empty count alone is not enough and that the retransmit request still fires.
- **An acknowledgement that over-covers the count.** This shows the clamp.
- **L0s eligibility.** L0s requests are tried with both pending-and-credit combinations.
- **Mixed L0s and L1 requests.** These separate the priority order and the exit rules.
- **Repeated tx_sent and a silent partner.** A packet sent in the very cycle after entry begins must block the grant. A long run with no acknowledgement must never produce a grant.

// File: rtl/lpg_pkg.sv
`timescale 1ns/1ps
package lpg_pkg;
    typedef enum logic [1:0] {ST_ACTIVE, ST_WAIT, ST_L0S, ST_L1} lpg_state_e;
    typedef enum logic [1:0] {TGT_NONE, TGT_L0S, TGT_L1} lpg_tgt_e;
endpackage

// File: rtl/lpg_req_select.sv
`timescale 1ns/1ps
module lpg_req_select
    import lpg_pkg::*;
#(
    parameter bit L1_FIRST = 1'b1
) (
    input  logic     sw_l1_req,
    input  logic     hw_l1_req,
    input  logic     hw_l0s_req,
    input  logic     tx_pending,
    input  logic     fc_credit_ok,
    output lpg_tgt_e tgt
);
    logic l1_want;
    logic l0s_ok;

    always_comb begin
        l1_want = sw_l1_req | hw_l1_req;
        // standby is allowed only when nothing can be sent right now
        l0s_ok  = hw_l0s_req & (~tx_pending | ~fc_credit_ok);
    end

    generate
        if (L1_FIRST) begin : g_l1_first
            always_comb begin
                if (l1_want)     tgt = TGT_L1;
                else if (l0s_ok) tgt = TGT_L0S;
                else             tgt = TGT_NONE;
            end
        end else begin : g_l0s_first
            always_comb begin
                if (l0s_ok)       tgt = TGT_L0S;
                else if (l1_want) tgt = TGT_L1;
                else              tgt = TGT_NONE;
            end
        end
    endgenerate
endmodule

// File: rtl/lpg_retry_tracker.sv
`timescale 1ns/1ps
module lpg_retry_tracker #(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_sent,
    input  logic             ack_valid,
    input  logic [CNT_W-1:0] ack_count,
    input  logic             nak_valid,
    input  logic             retx_done,
    output logic             buf_empty,
    output logic             retx_req
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             busy;
        logic             retx;
    } trk_t;

    trk_t cur_q, nxt_d;
    logic [SUM_W-1:0] sum_d;

    always_comb begin
        nxt_d = cur_q;
        sum_d = {1'b0, cur_q.count} + SUM_W'(tx_sent && (cur_q.count != FULL));
        if (ack_valid) begin
            if ({1'b0, ack_count} >= sum_d) sum_d = '0;
            else                            sum_d = sum_d - {1'b0, ack_count};
        end
        nxt_d.count = sum_d[CNT_W-1:0];
        if (nak_valid)      nxt_d.busy = 1'b1;
        else if (retx_done) nxt_d.busy = 1'b0;
        nxt_d.retx = nak_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign buf_empty = (cur_q.count == '0) && !cur_q.busy;
    assign retx_req  = cur_q.retx;

    // R4: a negative acknowledgement always produces a retransmit request
    a_r4_nak_retx: assert property (@(posedge clk) disable iff (!rst_n)
        nak_valid |=> retx_req);
    // R3: nak alone leaves the outstanding count untouched
    a_r3_nak_hold: assert property (@(posedge clk) disable iff (!rst_n)
        nak_valid && !tx_sent && !ack_valid |=> $stable(cur_q.count));
    // R2: a pending retransmission keeps the buffer non-empty
    a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        nak_valid |=> !buf_empty);
endmodule

// File: rtl/lpg_entry_fsm.sv
`timescale 1ns/1ps
module lpg_entry_fsm
    import lpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lpg_tgt_e tgt,
    input  logic     tx_sent,
    input  logic     buf_empty,
    output logic     grant_l0s,
    output logic     grant_l1
);
    typedef struct packed {
        lpg_state_e st;
        lpg_tgt_e   goal;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_ACTIVE: begin
                if (tgt != TGT_NONE) begin
                    nxt_d.st   = ST_WAIT;
                    nxt_d.goal = tgt;
                end
            end
            ST_WAIT: begin
                if (tx_sent || (tgt != cur_q.goal))
                    nxt_d.st = ST_ACTIVE;
                else if (buf_empty)
                    nxt_d.st = (cur_q.goal == TGT_L1) ? ST_L1 : ST_L0S;
            end
            ST_L0S: begin
                if (tx_sent || (tgt != TGT_L0S)) nxt_d.st = ST_ACTIVE;
            end
            ST_L1: begin
                if (tgt != TGT_L1) nxt_d.st = ST_ACTIVE;
            end
            default: nxt_d.st = ST_ACTIVE;
        endcase
        if (nxt_d.st == ST_ACTIVE) nxt_d.goal = TGT_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{st: ST_ACTIVE, goal: TGT_NONE};
        else        cur_q <= nxt_d;
    end

    assign grant_l0s = (cur_q.st == ST_L0S);
    assign grant_l1  = (cur_q.st == ST_L1);

    // R2: a grant may only appear after the tracker reported an empty buffer
    a_r2_grant_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_l0s) || $rose(grant_l1) |-> $past(buf_empty));
    // R12: the two low-power grants are exclusive
    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_l0s && grant_l1));
    // R9: a new packet pulls the link out of standby
    a_r9_tx_exits_l0s: assert property (@(posedge clk) disable iff (!rst_n)
        grant_l0s && tx_sent |=> !grant_l0s);
    // R10: L1 is held while an L1 request persists
    a_r10_l1_held: assert property (@(posedge clk) disable iff (!rst_n)
        grant_l1 && (tgt == TGT_L1) |=> grant_l1);
endmodule

// File: rtl/link_lowpower_gate.sv
`timescale 1ns/1ps
module link_lowpower_gate
    import lpg_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_l1_req,
    input  logic             hw_l1_req,
    input  logic             hw_l0s_req,
    input  logic             tx_sent,
    input  logic             ack_valid,
    input  logic [CNT_W-1:0] ack_count,
    input  logic             nak_valid,
    input  logic             retx_done,
    input  logic             tx_pending,
    input  logic             fc_credit_ok,
    output logic             grant_l0s,
    output logic             grant_l1,
    output logic             retx_req
);
    lpg_tgt_e tgt;
    logic     buf_empty;

    lpg_req_select #(.L1_FIRST(1'b1)) u_sel (
        .sw_l1_req   (sw_l1_req),
        .hw_l1_req   (hw_l1_req),
        .hw_l0s_req  (hw_l0s_req),
        .tx_pending  (tx_pending),
        .fc_credit_ok(fc_credit_ok),
        .tgt         (tgt)
    );

    lpg_retry_tracker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_sent  (tx_sent),
        .ack_valid(ack_valid),
        .ack_count(ack_count),
        .nak_valid(nak_valid),
        .retx_done(retx_done),
        .buf_empty(buf_empty),
        .retx_req (retx_req)
    );

    lpg_entry_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt      (tgt),
        .tx_sent  (tx_sent),
        .buf_empty(buf_empty),
        .grant_l0s(grant_l0s),
        .grant_l1 (grant_l1)
    );
endmodule

// File: tb/link_lowpower_gate_test.sv
`timescale 1ns/1ps
module link_lowpower_gate_test;
    localparam int DEPTH = 32;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_l1_req = 0, hw_l1_req = 0, hw_l0s_req = 0;
    logic tx_sent = 0, ack_valid = 0, nak_valid = 0, retx_done = 0;
    logic [CNT_W-1:0] ack_count = '0;
    logic tx_pending = 0, fc_credit_ok = 1;
    logic grant_l0s, grant_l1, retx_req;

    always #10 clk = ~clk;

    link_lowpower_gate #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .sw_l1_req(sw_l1_req), .hw_l1_req(hw_l1_req), .hw_l0s_req(hw_l0s_req),
        .tx_sent(tx_sent), .ack_valid(ack_valid), .ack_count(ack_count),
        .nak_valid(nak_valid), .retx_done(retx_done),
        .tx_pending(tx_pending), .fc_credit_ok(fc_credit_ok),
        .grant_l0s(grant_l0s), .grant_l1(grant_l1), .retx_req(retx_req)
    );

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int    vectors = 0;
    int    errors  = 0;
    bit    done    = 0;

    // monitor: compares outputs midway after each rising edge
    always begin
        @(posedge clk);
        #5;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            vectors++;
            if ({grant_l0s, grant_l1, retx_req} !== it.exp) begin
                errors++;
                $display("FAIL %s: got {l0s,l1,retx}=%b expected %b",
                         it.tag, {grant_l0s, grant_l1, retx_req}, it.exp);
            end
        end
    end

    // driver: queue the expectation for the coming edge, then clear pulses
    task automatic tick(input logic [2:0] e, input string tag);
        sb.push_back('{exp: e, tag: tag});
        @(negedge clk);
        tx_sent = 0; ack_valid = 0; ack_count = '0; nak_valid = 0; retx_done = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        tick(3'b000, "R1");
        tick(3'b000, "R1");
        rst_n = 1;
        tick(3'b000, "R1");

        // R5/R3: software L1 with two outstanding packets
        tx_sent = 1; tick(3'b000, "R3");
        tx_sent = 1; tick(3'b000, "R3");
        sw_l1_req = 1; tick(3'b000, "R2");
        tick(3'b000, "R2");
        ack_valid = 1; ack_count = 1; tick(3'b000, "R2");
        tick(3'b000, "R3");
        ack_valid = 1; ack_count = 1; tick(3'b000, "R2");
        tick(3'b010, "R5");
        tick(3'b010, "R12");
        sw_l1_req = 0; tick(3'b000, "R10");

        // R4/R6: nak during a pending hardware L1 entry
        tx_sent = 1; tick(3'b000, "R3");
        hw_l1_req = 1; tick(3'b000, "R2");
        nak_valid = 1; tick(3'b001, "R4");
        tick(3'b000, "R4");
        ack_valid = 1; ack_count = 1; tick(3'b000, "R2");
        tick(3'b000, "R2");
        retx_done = 1; tick(3'b000, "R2");
        tick(3'b010, "R6");
        hw_l1_req = 0; tick(3'b000, "R10");

        // R7: L0s eligibility
        hw_l0s_req = 1; tx_pending = 1; fc_credit_ok = 1;
        tick(3'b000, "R7");
        tick(3'b000, "R7");
        fc_credit_ok = 0; tick(3'b000, "R7");
        tick(3'b100, "R7");
        tick(3'b100, "R12");
        // R9: transmit while in L0S
        tx_sent = 1; tick(3'b000, "R9");
        tick(3'b000, "R2");
        tick(3'b000, "R2");
        ack_valid = 1; ack_count = 1; tick(3'b000, "R2");
        tick(3'b100, "R7");
        // R9: eligibility withdrawn
        fc_credit_ok = 1; tick(3'b000, "R9");

        // R8: priority of L1 over L0s
        tx_pending = 0; sw_l1_req = 1; tick(3'b000, "R8");
        tick(3'b010, "R8");
        sw_l1_req = 0; tick(3'b000, "R10");
        tick(3'b000, "R8");
        tick(3'b100, "R8");
        sw_l1_req = 1; tick(3'b000, "R8");
        tick(3'b000, "R8");
        tick(3'b010, "R8");
        sw_l1_req = 0; hw_l0s_req = 0; tick(3'b000, "R10");

        // R3: acknowledgement covering more than outstanding clamps to zero
        tx_sent = 1; tick(3'b000, "R3");
        tx_sent = 1; tick(3'b000, "R3");
        ack_valid = 1; ack_count = 7; tick(3'b000, "R3");
        hw_l1_req = 1; tick(3'b000, "R3");
        tick(3'b010, "R3");
        hw_l1_req = 0; tick(3'b000, "R10");

        // R9/R2: packet sent in the first WAIT_EMPTY cycle blocks the grant
        sw_l1_req = 1; tick(3'b000, "R9");
        tx_sent = 1; tick(3'b000, "R9");
        ack_valid = 1; ack_count = 1; tick(3'b000, "R9");
        tick(3'b010, "R5");
        sw_l1_req = 0; tick(3'b000, "R10");

        // R11: silent partner, request held
        tx_sent = 1; tick(3'b000, "R11");
        sw_l1_req = 1;
        for (int i = 0; i < 40; i++) tick(3'b000, "R11");
        sw_l1_req = 0; ack_valid = 1; ack_count = 1; tick(3'b000, "R11");
        tick(3'b000, "R11");

        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule